// File: doc/BRIEF.md
# SIMD Lane Permute Unit

This block performs the three two-register element shuffles of a SIMD unit: interleave, de-interleave and pairwise transpose. An issue stage presents a 32-bit instruction word with two source vectors read from the register file. The unit decodes the operation, the element width (8, 16 or 32 bits) and the vector length (64 or 128 bits). It rearranges the elements and returns two result vectors one cycle later. The write-back logic stores the first result in the register named by the destination field and the second in the register named by the second-operand field, so both sources are overwritten.

Doubleword operations use only the low 64 bits of each source. Their results come back zero-extended and are marked as doubleword writes. An encoding outside the three permute patterns, or one with the reserved element-size value, comes back with an illegal flag and requests no write.

Top module: `simd_lane_permute`

## Requirements
- R1: With instruction bits [17:16] = 2 and bits [11:8] = 1, the word is a pairwise operation: bit 7 = 1 selects interleave and bit 7 = 0 selects de-interleave. A result is produced with out_wr_en = 1 and out_illegal = 0.
- R2: With bits [17:16] = 2 and bits [11:7] = 5'b00001, the word is a transpose and is accepted with out_wr_en = 1.
- R3: Bits [19:18] give the element width: 0 means 8, 1 means 16 and 2 means 32 bits. The value 3 makes the word illegal.
- R4: Interleave with N elements per vector: first[2i] = A[i] and first[2i+1] = B[i]. second[2i] = A[i+N/2] and second[2i+1] = B[i+N/2]. Element k occupies bits [k*W +: W].
- R5: De-interleave: the low half of the first result holds A's even elements and its high half holds B's even elements. The second result holds the odd elements in the same arrangement.
- R6: Transpose exchanges A[2i+1] with B[2i] for every i. The first result carries the updated A and the second result carries the updated B.
- R7: Bit 6 = 0 selects 64-bit vectors. Only source bits [63:0] are used, output bits [127:64] are zero and out_dword = 1. Bit 6 = 1 selects 128-bit vectors with out_dword = 0.
- R8: An illegal word gives out_illegal = 1 with out_valid, together with out_wr_en = 0, out_dword = 0 and all-zero results.
- R9: out_valid follows in_valid by exactly one clock. While in_valid is low, the result outputs hold their values.
- R10: During reset, out_valid, out_illegal, out_wr_en and out_dword are 0.
- R11: With 64-bit vectors and 32-bit elements, interleave and de-interleave produce identical results: first = {B[0], A[0]} and second = {B[1], A[1]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction and operands present |
| in_instr | input | 32 | Instruction word |
| in_src_a | input | 128 | Vector named by the destination field (A) |
| in_src_b | input | 128 | Vector named by the second-operand field (B) |
| out_valid | output | 1 | Result present, one cycle after in_valid |
| out_illegal | output | 1 | Reserved or non-permute encoding |
| out_wr_en | output | 1 | Write both results back |
| out_dword | output | 1 | Results are 64-bit writes |
| out_res_first | output | 128 | Result for the destination register |
| out_res_second | output | 128 | Result for the second-operand register |

## Verification
The assertions check the control side of the block on every cycle. They cover the one-cycle valid latency, that results hold while idle, the zeroed upper half of doubleword results, and that an illegal word never requests a write. They also cover how each permute pattern and the reserved size map onto the write and illegal flags. The lane arrangement of interleave, de-interleave and transpose can only be shown by the bench scenarios. These sweep every operation, element width and vector length over several data patterns and compare against a model indexed per output element. The same holds for the equivalence of the 32-bit doubleword cases.

// File: rtl/perm_pkg.sv
package perm_pkg;
  typedef enum logic [1:0] {
    PERM_ZIP = 2'd0,
    PERM_UZP = 2'd1,
    PERM_TRN = 2'd2,
    PERM_NOP = 2'd3
  } perm_op_e;

  typedef struct packed {
    logic     legal;
    perm_op_e op;
    logic [1:0] esize;
    logic     quad;
  } perm_ctl_t;
endpackage

// File: rtl/perm_decode.sv
module perm_decode
  import perm_pkg::*;
(
  input  logic [31:0] instr,
  output perm_ctl_t   ctl
);
  logic is_pair;
  logic is_trn;
  logic unused_bits;

  assign unused_bits = ^{instr[31:20], instr[15:12], instr[5:0]};

  always_comb begin
    is_pair   = (instr[17:16] == 2'b10) && (instr[11:8] == 4'h1);
    is_trn    = (instr[17:16] == 2'b10) && (instr[11:7] == 5'b00001);
    ctl.esize = instr[19:18];
    ctl.quad  = instr[6];
    ctl.legal = (is_pair || is_trn) && (instr[19:18] != 2'b11);
    if (is_pair)     ctl.op = instr[7] ? PERM_ZIP : PERM_UZP;
    else if (is_trn) ctl.op = PERM_TRN;
    else             ctl.op = PERM_NOP;
  end
endmodule

// File: rtl/perm_lanes.sv
module perm_lanes
  import perm_pkg::*;
#(
  parameter int EW = 8,
  parameter int VW = 128
) (
  input  logic [VW-1:0] a,
  input  logic [VW-1:0] b,
  input  perm_op_e      op,
  output logic [VW-1:0] r1,
  output logic [VW-1:0] r2
);
  localparam int N = VW / EW;
  localparam int H = N / 2;

  always_comb begin
    r1 = '0;
    r2 = '0;
    for (int i = 0; i < H; i++) begin
      case (op)
        PERM_ZIP: begin
          r1[(2*i)*EW +: EW]   = a[i*EW +: EW];
          r1[(2*i+1)*EW +: EW] = b[i*EW +: EW];
          r2[(2*i)*EW +: EW]   = a[(i+H)*EW +: EW];
          r2[(2*i+1)*EW +: EW] = b[(i+H)*EW +: EW];
        end
        PERM_UZP: begin
          r1[i*EW +: EW]     = a[(2*i)*EW +: EW];
          r1[(i+H)*EW +: EW] = b[(2*i)*EW +: EW];
          r2[i*EW +: EW]     = a[(2*i+1)*EW +: EW];
          r2[(i+H)*EW +: EW] = b[(2*i+1)*EW +: EW];
        end
        PERM_TRN: begin
          r1[(2*i)*EW +: EW]   = a[(2*i)*EW +: EW];
          r1[(2*i+1)*EW +: EW] = b[(2*i)*EW +: EW];
          r2[(2*i)*EW +: EW]   = a[(2*i+1)*EW +: EW];
          r2[(2*i+1)*EW +: EW] = b[(2*i+1)*EW +: EW];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/simd_lane_permute.sv
module simd_lane_permute
  import perm_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int MIN_EW = 8,
  parameter int NUM_SZ = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_instr,
  input  logic [DATA_W-1:0] in_src_a,
  input  logic [DATA_W-1:0] in_src_b,
  output logic              out_valid,
  output logic              out_illegal,
  output logic              out_wr_en,
  output logic              out_dword,
  output logic [DATA_W-1:0] out_res_first,
  output logic [DATA_W-1:0] out_res_second
);
  localparam int HALF_W = DATA_W / 2;

  // reset release synchroniser
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  perm_ctl_t ctl;
  perm_decode u_dec (.instr(in_instr), .ctl(ctl));

  // one lane network per element width and vector length
  logic [DATA_W-1:0] cand1 [NUM_SZ][2];
  logic [DATA_W-1:0] cand2 [NUM_SZ][2];

  for (genvar s = 0; s < NUM_SZ; s++) begin : g_size
    for (genvar l = 0; l < 2; l++) begin : g_len
      localparam int VW = (l == 1) ? DATA_W : HALF_W;
      logic [VW-1:0] r1_w;
      logic [VW-1:0] r2_w;
      perm_lanes #(.EW(MIN_EW << s), .VW(VW)) u_lanes (
        .a (in_src_a[VW-1:0]),
        .b (in_src_b[VW-1:0]),
        .op(ctl.op),
        .r1(r1_w),
        .r2(r2_w)
      );
      if (l == 1) begin : g_full
        assign cand1[s][l] = r1_w;
        assign cand2[s][l] = r2_w;
      end else begin : g_half
        assign cand1[s][l] = {{(DATA_W-VW){1'b0}}, r1_w};
        assign cand2[s][l] = {{(DATA_W-VW){1'b0}}, r2_w};
      end
    end
  end

  // next-state
  logic              nxt_valid, nxt_illegal, nxt_wr_en, nxt_dword;
  logic [DATA_W-1:0] nxt_res1, nxt_res2;
  logic              load_en;

  always_comb begin
    load_en     = in_valid;
    nxt_valid   = in_valid;
    nxt_illegal = in_valid && !ctl.legal;
    nxt_wr_en   = in_valid && ctl.legal;
    nxt_dword   = in_valid && ctl.legal && !ctl.quad;
    nxt_res1    = '0;
    nxt_res2    = '0;
    if (ctl.legal) begin
      case (ctl.esize)
        2'd0: begin nxt_res1 = cand1[0][ctl.quad]; nxt_res2 = cand2[0][ctl.quad]; end
        2'd1: begin nxt_res1 = cand1[1][ctl.quad]; nxt_res2 = cand2[1][ctl.quad]; end
        2'd2: begin nxt_res1 = cand1[2][ctl.quad]; nxt_res2 = cand2[2][ctl.quad]; end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_wr_en   <= 1'b0;
      out_dword   <= 1'b0;
    end else begin
      out_valid   <= nxt_valid;
      out_illegal <= nxt_illegal;
      out_wr_en   <= nxt_wr_en;
      if (load_en) out_dword <= nxt_dword;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      out_res_first  <= '0;
      out_res_second <= '0;
    end else if (load_en) begin
      out_res_first  <= nxt_res1;
      out_res_second <= nxt_res2;
    end
  end
endmodule

// File: rtl/simd_lane_permute_chk.sv
module simd_lane_permute_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              in_valid,
  input logic [31:0]       in_instr,
  input logic              out_valid,
  input logic              out_illegal,
  input logic              out_wr_en,
  input logic              out_dword,
  input logic [DATA_W-1:0] out_res_first,
  input logic [DATA_W-1:0] out_res_second
);
  localparam int HALF_W = DATA_W / 2;

  p_pair_accept_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && in_instr[17:16] == 2'b10 && in_instr[11:8] == 4'h1 && in_instr[19:18] != 2'b11)
      |=> (out_wr_en && !out_illegal));

  p_trn_accept_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && in_instr[17:16] == 2'b10 && in_instr[11:7] == 5'b00001 && in_instr[19:18] != 2'b11)
      |=> (out_wr_en && !out_illegal));

  p_size3_illegal_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && in_instr[19:18] == 2'b11) |=> (out_illegal && !out_wr_en));

  p_dword_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (out_valid && out_dword) |->
      (out_res_first[DATA_W-1:HALF_W] == '0 && out_res_second[DATA_W-1:HALF_W] == '0));

  p_illegal_no_write_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    out_illegal |-> (out_valid && !out_wr_en && !out_dword));

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_valid);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> (!out_valid && $stable(out_res_first) && $stable(out_res_second)));

  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({out_illegal, out_wr_en}));
endmodule

bind simd_lane_permute simd_lane_permute_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_ok        (rst_s_n),
  .in_valid      (in_valid),
  .in_instr      (in_instr),
  .out_valid     (out_valid),
  .out_illegal   (out_illegal),
  .out_wr_en     (out_wr_en),
  .out_dword     (out_dword),
  .out_res_first (out_res_first),
  .out_res_second(out_res_second)
);

// File: tb/simd_lane_permute_tb_top.sv
`timescale 1ns/1ps
module simd_lane_permute_tb_top;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  in_instr;
  logic [127:0] in_src_a, in_src_b;
  logic         out_valid, out_illegal, out_wr_en, out_dword;
  logic [127:0] out_res_first, out_res_second;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  simd_lane_permute dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_src_a(in_src_a), .in_src_b(in_src_b),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_wr_en(out_wr_en),
    .out_dword(out_dword), .out_res_first(out_res_first), .out_res_second(out_res_second)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-output-element reference
  function automatic void model(input logic [31:0] ins, input logic [127:0] a, input logic [127:0] b,
                                output logic [127:0] e1, output logic [127:0] e2,
                                output bit legal, output bit dw);
    int sz, ew, n, h, mode;
    bit pair, trn;
    e1 = '0; e2 = '0;
    pair = (ins[17:16] == 2'd2) && (ins[11:8] == 4'd1);
    trn  = (ins[17:16] == 2'd2) && (ins[11:8] == 4'd0) && ins[7];
    sz   = int'(ins[19:18]);
    legal = (pair || trn) && (sz != 3);
    dw = legal && !ins[6];
    if (!legal) return;
    mode = trn ? 2 : (ins[7] ? 0 : 1);
    ew = 8 * (1 << sz);
    n  = (ins[6] ? 128 : 64) / ew;
    h  = n / 2;
    for (int j = 0; j < n; j++) begin
      logic [31:0] v1, v2;
      case (mode)
        0: begin
          v1 = (j % 2 == 0) ? a[(j/2)*ew +: 32] : b[(j/2)*ew +: 32];
          v2 = (j % 2 == 0) ? a[(j/2+h)*ew +: 32] : b[(j/2+h)*ew +: 32];
        end
        1: begin
          v1 = (j < h) ? a[(2*j)*ew +: 32] : b[(2*(j-h))*ew +: 32];
          v2 = (j < h) ? a[(2*j+1)*ew +: 32] : b[(2*(j-h)+1)*ew +: 32];
        end
        default: begin
          v1 = (j % 2 == 0) ? a[j*ew +: 32] : b[(j-1)*ew +: 32];
          v2 = (j % 2 == 0) ? a[(j+1)*ew +: 32] : b[j*ew +: 32];
        end
      endcase
      for (int k = 0; k < ew; k++) begin
        e1[j*ew + k] = v1[k];
        e2[j*ew + k] = v2[k];
      end
    end
  endfunction

  function automatic logic [31:0] make_instr(input int mode, input int sz, input bit q);
    logic [31:0] w;
    w = $urandom;
    w[19:18] = sz[1:0];
    w[17:16] = 2'b10;
    w[6] = q;
    if (mode == 2) w[11:7] = 5'b00001;
    else begin w[11:8] = 4'h1; w[7] = (mode == 0); end
    return w;
  endfunction

  function automatic logic [127:0] make_data(input int pat, input int salt);
    logic [127:0] d;
    for (int k = 0; k < 16; k++) begin
      case (pat)
        0: d[k*8 +: 8] = 8'(k + salt);
        1: d[k*8 +: 8] = 8'($urandom);
        2: d[k*8 +: 8] = (k % 2 == 0) ? 8'hFF : 8'h00;
        default: d[k*8 +: 8] = 8'(255 - k - salt);
      endcase
    end
    return d;
  endfunction

  logic [127:0] last1, last2;

  task automatic run_one(input logic [31:0] ins, input logic [127:0] a, input logic [127:0] b, input string tag);
    logic [127:0] e1, e2;
    bit lg, dw;
    model(ins, a, b, e1, e2, lg, dw);
    in_valid = 1'b1; in_instr = ins; in_src_a = a; in_src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R9 valid latency", 128'(out_valid), 128'd1);
    check(out_illegal == !lg && out_wr_en == lg, {tag, " R8 flags"},
          128'({out_illegal, out_wr_en}), 128'({!lg, lg}));
    check(out_dword == dw, {tag, " R7 dword flag"}, 128'(out_dword), 128'(dw));
    check(out_res_first == e1, {tag, " first result"}, out_res_first, e1);
    check(out_res_second == e2, {tag, " second result"}, out_res_second, e2);
    last1 = out_res_first; last2 = out_res_second;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [127:0] a, b;
    rst_n = 1'b0; in_valid = 1'b0; in_instr = '0; in_src_a = '0; in_src_b = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check({out_valid, out_illegal, out_wr_en, out_dword} == 4'b0, "R10 reset outputs",
          128'({out_valid, out_illegal, out_wr_en, out_dword}), 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R10 idle after reset", 128'(out_valid), 128'd0);

    // R1 R2 R3 R4 R5 R6 R7 sweep
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 4; s++)
        for (int q = 0; q < 2; q++)
          for (int p = 0; p < 4; p++) begin
            a = make_data(p, 0);
            b = make_data(p, 100);
            if (p == 2) b = ~b;
            run_one(make_instr(m, s, q[0]), a, b,
                    m == 0 ? "R4 R1 zip" : (m == 1 ? "R5 R1 unzip" : "R6 R2 transpose"));
          end

    // R7: upper source bits must not matter for doubleword
    a = make_data(1, 0); b = make_data(1, 0);
    w = make_instr(0, 0, 1'b0);
    run_one(w, a, b, "R7 upper ignored base");
    a[127:64] = ~a[127:64]; b[127:64] = ~b[127:64];
    run_one(w, a, b, "R7 upper ignored flipped");

    // R11: 32-bit doubleword zip equals unzip
    a = make_data(1, 0); b = make_data(1, 0);
    run_one(make_instr(0, 2, 1'b0), a, b, "R11 zip32d");
    begin
      logic [127:0] z1, z2;
      z1 = last1; z2 = last2;
      run_one(make_instr(1, 2, 1'b0), a, b, "R11 unzip32d");
      check(last1 == z1 && last2 == z2, "R11 zip equals unzip", last1, z1);
      check(z1[63:0] == {b[31:0], a[31:0]}, "R11 first layout", z1, {64'd0, b[31:0], a[31:0]});
    end

    // R8 / R3: illegal encodings
    for (int i = 0; i < 12; i++) begin
      w = $urandom;
      case (i % 3)
        0: begin w[17:16] = 2'(i % 2); end
        1: begin w[17:16] = 2'b10; w[11:8] = 4'h2 + 4'(i % 7); end
        default: begin w = make_instr(i % 3, 3, 1'($urandom)); end
      endcase
      run_one(w, make_data(1, i), make_data(1, i), "R8 R3 illegal");
    end

    // R9 hold while idle
    run_one(make_instr(2, 1, 1'b1), make_data(1, 0), make_data(1, 5), "R9 prep");
    in_instr = make_instr(0, 0, 1'b1); in_src_a = ~in_src_a; in_src_b = ~in_src_b;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 idle no valid", 128'(out_valid), 128'd0);
    check(out_res_first == last1 && out_res_second == last2, "R9 hold results", out_res_first, last1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule